// File: doc/BRIEF.md
# Peripheral Read-Back Response Parser

After a bus turnaround, a display peripheral leaves a short queue of 32-bit words for the host to read. This block consumes one such response from a show-ahead word queue, classifies the leading status word, decodes the typed header that may follow, and turns the result into flags, a 16-bit error bitmap, a reported long-read length, or a stream of data bytes.

Parsing begins when the queue's level input becomes nonzero. The block captures that level as the length of the response and pops exactly that many words. The first word is the status word. The second word, if there is one, is the header. Any further words are payload. Payload bytes leave least significant byte first, one per cycle, until a budget is used up. The budget is the smaller of the reported length and the caller's limit. Payload words beyond the budget are still popped and are dropped. Results hold until the next response starts, and a one-cycle done pulse closes each response.

Top module: `rsp_parser`

## Requirements
- R1: After reset, no pop is requested, no byte is valid, done is low, and all flags and valid outputs are low.
- R2: A status word equal to 0x00000084 sets st_ack. A status word equal to 0x00000087 sets st_esc. Any other status word sets st_unknown. Exactly one of the three is high after a response.
- R3: Parsing starts only when fifo_level is nonzero. A response of one word consumes only the status word, produces no bytes, and leaves err_valid, len_valid and unhandled low.
- R4: The header data type is bits 5:0 of the second word. For type 0x02 (error report), err_valid rises and err_map takes bits 23:8. Bit 0 is the start-of-transmission error and bit 15 is the protocol violation. No bytes are produced.
- R5: Type 0x21 emits one byte, bits 15:8. Type 0x22 emits two bytes, bits 15:8 and then bits 23:16. The caller's limit does not clip these.
- R6: Types 0x1A (generic long read) and 0x1C (command-set long read) raise len_valid and report long_len from bits 23:8.
- R7: Long-read payload words are emitted least significant byte first. The byte count is the minimum of long_len, req_len (sampled at start) and four bytes per payload word present.
- R8: Any other header type raises unhandled and produces no bytes. At most one of err_valid, len_valid and unhandled is high.
- R9: Exactly the captured number of words is popped per response, and no pop occurs while the level is zero.
- R10: resp_done pulses for exactly one cycle per response, after the last word and the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | CNT_W | Words waiting in the response queue |
| fifo_word | input | 32 | Head word of the queue (show-ahead) |
| fifo_pop | output | 1 | Consume the head word this cycle |
| req_len | input | 16 | Caller's maximum long-read byte count |
| st_ack | output | 1 | Status word was acknowledge |
| st_esc | output | 1 | Status word was escape |
| st_unknown | output | 1 | Status word was neither |
| err_valid | output | 1 | Header was an error report |
| err_map | output | 16 | Error report bitmap |
| len_valid | output | 1 | Header was a long read |
| long_len | output | 16 | Reported long-read byte count |
| unhandled | output | 1 | Header type not recognised |
| byte_valid | output | 1 | A data byte is presented |
| byte_data | output | 8 | Data byte |
| resp_done | output | 1 | One-cycle end-of-response pulse |

## Verification
A corrupted word counter shows at the queue within a few cycles as the wrong number of words popped, which leaves stale words for the next response or pops an empty queue. A wrong byte budget or shift position shows on the byte stream in the same response as a wrong count, order or value. A misdecoded header shows in the header cycle as the wrong exclusive valid flag. Directed responses cover each status code, each header type, the clipping by length, word supply and limit, and the draining of surplus words.

// File: rtl/rsp_parse_pkg.sv
package rsp_parse_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 16;
    localparam int BYTE_W  = 8;
    localparam int NB_W    = 3;

    localparam logic [WORD_W-1:0] STS_ACK_WORD = 32'h0000_0084;
    localparam logic [WORD_W-1:0] STS_ESC_WORD = 32'h0000_0087;

    localparam logic [5:0] DT_ERR_REPORT = 6'h02;
    localparam logic [5:0] DT_SHORT_1B   = 6'h21;
    localparam logic [5:0] DT_SHORT_2B   = 6'h22;
    localparam logic [5:0] DT_LONG_GEN   = 6'h1A;
    localparam logic [5:0] DT_LONG_CMD   = 6'h1C;

    // Positions inside the error bitmap
    localparam int EB_SOT          = 0;
    localparam int EB_SOT_SYNC     = 1;
    localparam int EB_EOT_SYNC     = 2;
    localparam int EB_ESC_ENTRY    = 3;
    localparam int EB_LP_SYNC      = 4;
    localparam int EB_PERIPH_TMO   = 5;
    localparam int EB_FALSE_CTRL   = 6;
    localparam int EB_CONTENTION   = 7;
    localparam int EB_ECC_SINGLE   = 8;
    localparam int EB_ECC_MULTI    = 9;
    localparam int EB_CHECKSUM     = 10;
    localparam int EB_BAD_TYPE     = 11;
    localparam int EB_BAD_VC       = 12;
    localparam int EB_BAD_LEN      = 13;
    localparam int EB_RSVD         = 14;
    localparam int EB_PROTOCOL     = 15;

    typedef enum logic [1:0] {
        SK_ACK,
        SK_ESC,
        SK_UNK
    } sts_kind_e;

    typedef enum logic [2:0] {
        HK_ERR,
        HK_SHORT1,
        HK_SHORT2,
        HK_LONG,
        HK_OTHER
    } hdr_kind_e;

    typedef struct packed {
        hdr_kind_e          kind;
        logic [FIELD_W-1:0] field;
        logic [BYTE_W-1:0]  lo_byte;
        logic [BYTE_W-1:0]  hi_byte;
    } hdr_info_t;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_STATUS,
        PS_HDR,
        PS_PAYLOAD,
        PS_EMIT,
        PS_DONE
    } pstate_e;

    function automatic logic [FIELD_W-1:0] min_field(
        input logic [FIELD_W-1:0] a,
        input logic [FIELD_W-1:0] b
    );
        return (a < b) ? a : b;
    endfunction

    function automatic logic [NB_W-1:0] word_take(input logic [FIELD_W-1:0] budget);
        return (budget >= FIELD_W'(4)) ? NB_W'(4) : budget[NB_W-1:0];
    endfunction

endpackage

// File: rtl/rsp_status_cls.sv
module rsp_status_cls
    import rsp_parse_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output sts_kind_e         kind
);
    always_comb begin
        if (word == STS_ACK_WORD)
            kind = SK_ACK;
        else if (word == STS_ESC_WORD)
            kind = SK_ESC;
        else
            kind = SK_UNK;
    end
endmodule

// File: rtl/rsp_hdr_dec.sv
module rsp_hdr_dec
    import rsp_parse_pkg::*;
(
    input  logic [23:0] hdr,
    output hdr_info_t   info
);
    logic [5:0] dtype;

    assign dtype = hdr[5:0];

    always_comb begin
        info.field   = hdr[23:8];
        info.lo_byte = hdr[15:8];
        info.hi_byte = hdr[23:16];
        unique case (dtype)
            DT_ERR_REPORT:            info.kind = HK_ERR;
            DT_SHORT_1B:              info.kind = HK_SHORT1;
            DT_SHORT_2B:              info.kind = HK_SHORT2;
            DT_LONG_GEN, DT_LONG_CMD: info.kind = HK_LONG;
            default:                  info.kind = HK_OTHER;
        endcase
    end
endmodule

// File: rtl/rsp_byte_unpack.sv
module rsp_byte_unpack
    import rsp_parse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic [NB_W-1:0]   load_n,
    input  logic              shift,
    output logic [BYTE_W-1:0] byte_o,
    output logic              last_o
);
    logic [WORD_W-1:0] sh_q;
    logic [NB_W-1:0]   left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= load_word;
            left_q <= load_n;
        end else if (shift) begin
            sh_q   <= sh_q >> BYTE_W;
            left_q <= left_q - NB_W'(1);
        end
    end

    assign byte_o = sh_q[BYTE_W-1:0];
    assign last_o = (left_q == NB_W'(1));
endmodule

// File: rtl/rsp_parser.sv
module rsp_parser
    import rsp_parse_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   fifo_level,
    input  logic [31:0]        fifo_word,
    output logic               fifo_pop,
    input  logic [15:0]        req_len,
    output logic               st_ack,
    output logic               st_esc,
    output logic               st_unknown,
    output logic               err_valid,
    output logic [15:0]        err_map,
    output logic               len_valid,
    output logic [15:0]        long_len,
    output logic               unhandled,
    output logic               byte_valid,
    output logic [7:0]         byte_data,
    output logic               resp_done
);
    pstate_e            state_q;
    logic [CNT_W-1:0]   words_q;
    logic [FIELD_W-1:0] budget_q;
    logic [FIELD_W-1:0] req_q;

    sts_kind_e          sts_kind;
    hdr_info_t          hinfo;

    logic               up_load;
    logic [WORD_W-1:0]  up_word;
    logic [NB_W-1:0]    up_n;
    logic               up_shift;
    logic               up_last;
    logic [NB_W-1:0]    take;

    rsp_status_cls u_sts (
        .word (fifo_word),
        .kind (sts_kind)
    );

    rsp_hdr_dec u_hdr (
        .hdr  (fifo_word[23:0]),
        .info (hinfo)
    );

    rsp_byte_unpack u_unpack (
        .clk       (clk),
        .rst       (rst),
        .load      (up_load),
        .load_word (up_word),
        .load_n    (up_n),
        .shift     (up_shift),
        .byte_o    (byte_data),
        .last_o    (up_last)
    );

    assign take = word_take(budget_q);

    // Pop and unpacker control
    always_comb begin
        fifo_pop = 1'b0;
        up_load  = 1'b0;
        up_word  = fifo_word;
        up_n     = take;
        up_shift = 1'b0;
        unique case (state_q)
            PS_STATUS: fifo_pop = 1'b1;
            PS_HDR: begin
                fifo_pop = 1'b1;
                if (hinfo.kind == HK_SHORT1 || hinfo.kind == HK_SHORT2) begin
                    up_load = 1'b1;
                    up_word = {{(WORD_W-2*BYTE_W){1'b0}}, hinfo.hi_byte, hinfo.lo_byte};
                    up_n    = (hinfo.kind == HK_SHORT2) ? NB_W'(2) : NB_W'(1);
                end
            end
            PS_PAYLOAD: begin
                fifo_pop = (words_q != '0);
                up_load  = (words_q != '0) && (budget_q != '0);
            end
            PS_EMIT: up_shift = 1'b1;
            default: ;
        endcase
    end

    assign byte_valid = (state_q == PS_EMIT);
    assign resp_done  = (state_q == PS_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PS_IDLE;
            words_q    <= '0;
            budget_q   <= '0;
            req_q      <= '0;
            st_ack     <= 1'b0;
            st_esc     <= 1'b0;
            st_unknown <= 1'b0;
            err_valid  <= 1'b0;
            err_map    <= '0;
            len_valid  <= 1'b0;
            long_len   <= '0;
            unhandled  <= 1'b0;
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    if (fifo_level != '0) begin
                        words_q    <= fifo_level;
                        req_q      <= req_len;
                        budget_q   <= '0;
                        st_ack     <= 1'b0;
                        st_esc     <= 1'b0;
                        st_unknown <= 1'b0;
                        err_valid  <= 1'b0;
                        err_map    <= '0;
                        len_valid  <= 1'b0;
                        long_len   <= '0;
                        unhandled  <= 1'b0;
                        state_q    <= PS_STATUS;
                    end
                end
                PS_STATUS: begin
                    st_ack     <= (sts_kind == SK_ACK);
                    st_esc     <= (sts_kind == SK_ESC);
                    st_unknown <= (sts_kind == SK_UNK);
                    words_q    <= words_q - CNT_W'(1);
                    state_q    <= (words_q == CNT_W'(1)) ? PS_DONE : PS_HDR;
                end
                PS_HDR: begin
                    words_q <= words_q - CNT_W'(1);
                    unique case (hinfo.kind)
                        HK_ERR: begin
                            err_valid <= 1'b1;
                            err_map   <= hinfo.field;
                            state_q   <= PS_PAYLOAD;
                        end
                        HK_SHORT1, HK_SHORT2: state_q <= PS_EMIT;
                        HK_LONG: begin
                            len_valid <= 1'b1;
                            long_len  <= hinfo.field;
                            budget_q  <= min_field(hinfo.field, req_q);
                            state_q   <= PS_PAYLOAD;
                        end
                        default: begin
                            unhandled <= 1'b1;
                            state_q   <= PS_PAYLOAD;
                        end
                    endcase
                end
                PS_PAYLOAD: begin
                    if (words_q == '0) begin
                        state_q <= PS_DONE;
                    end else begin
                        words_q <= words_q - CNT_W'(1);
                        if (budget_q != '0) begin
                            budget_q <= budget_q - FIELD_W'(take);
                            state_q  <= PS_EMIT;
                        end
                    end
                end
                PS_EMIT: begin
                    if (up_last)
                        state_q <= PS_PAYLOAD;
                end
                PS_DONE: state_q <= PS_IDLE;
                default: state_q <= PS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rsp_parser_chk.sv
module rsp_parser_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] fifo_level,
    input logic             fifo_pop,
    input logic             st_ack,
    input logic             st_esc,
    input logic             st_unknown,
    input logic             err_valid,
    input logic             len_valid,
    input logic             unhandled,
    input logic             byte_valid,
    input logic             resp_done
);
    AST_POP_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (fifo_level != '0)); // R9

    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_ack, st_esc, st_unknown})); // R2

    AST_HEADER_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_valid, len_valid, unhandled})); // R8

    AST_NO_BYTE_UNHANDLED: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> !unhandled && !err_valid); // R8

    AST_NO_POP_WHILE_EMIT: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> !fifo_pop); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        resp_done |=> !resp_done); // R10

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        resp_done |-> !fifo_pop && !byte_valid); // R10
endmodule

bind rsp_parser rsp_parser_chk #(.CNT_W(CNT_W)) u_rsp_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_level (fifo_level),
    .fifo_pop   (fifo_pop),
    .st_ack     (st_ack),
    .st_esc     (st_esc),
    .st_unknown (st_unknown),
    .err_valid  (err_valid),
    .len_valid  (len_valid),
    .unhandled  (unhandled),
    .byte_valid (byte_valid),
    .resp_done  (resp_done)
);

// File: tb/tb_rsp_parser.sv
module tb_rsp_parser;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] fifo_level;
    logic [31:0]      fifo_word;
    logic             fifo_pop;
    logic [15:0]      req_len = '0;
    logic             st_ack, st_esc, st_unknown;
    logic             err_valid, len_valid, unhandled;
    logic [15:0]      err_map, long_len;
    logic             byte_valid;
    logic [7:0]       byte_data;
    logic             resp_done;

    always #10 clk = ~clk;

    rsp_parser #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .fifo_level(fifo_level), .fifo_word(fifo_word),
        .fifo_pop(fifo_pop), .req_len(req_len), .st_ack(st_ack), .st_esc(st_esc),
        .st_unknown(st_unknown), .err_valid(err_valid), .err_map(err_map),
        .len_valid(len_valid), .long_len(long_len), .unhandled(unhandled),
        .byte_valid(byte_valid), .byte_data(byte_data), .resp_done(resp_done)
    );

    // Show-ahead response queue model
    logic [31:0]      mem [32];
    logic [CNT_W-1:0] wrp = '0;
    logic [CNT_W-1:0] rdp = '0;
    assign fifo_level = wrp - rdp;
    assign fifo_word  = mem[rdp];
    always @(posedge clk) if (!rst && fifo_pop) rdp <= rdp + 1'b1;

    int checks = 0;
    int fails  = 0;
    int nb     = 0;
    int ndone  = 0;
    logic [7:0]  got [64];
    logic [31:0] w   [8];

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                if (nb < 64) got[nb] = byte_data;
                nb++;
            end
            if (resp_done) ndone++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run(input int n, input logic [15:0] lim);
        bit seen = 0;
        @(negedge clk);
        nb = 0; ndone = 0;
        req_len = lim;
        for (int i = 0; i < n; i++) mem[wrp + CNT_W'(i)] = w[i];
        wrp = wrp + CNT_W'(n);
        for (int c = 0; c < 400 && !seen; c++) begin
            @(negedge clk);
            if (resp_done) seen = 1;
        end
        check("R10 done seen", 32'(seen), 1);
        repeat (3) @(negedge clk);
        check("R10 single done", 32'(ndone), 1);
        check("R9 queue drained", 32'(fifo_level), 0);
    endtask

    task automatic t_reset();
        check("R1 pop", 32'(fifo_pop), 0);
        check("R1 byte_valid", 32'(byte_valid), 0);
        check("R1 done", 32'(resp_done), 0);
        check("R1 flags", {26'b0, st_ack, st_esc, st_unknown, err_valid, len_valid, unhandled}, 0);
    endtask

    task automatic t_ack_only();
        w[0] = 32'h84;
        run(1, 16'd8);
        check("R2 ack", {st_ack, st_esc, st_unknown}, 3'b100);
        check("R3 no bytes", 32'(nb), 0);
        check("R3 no header flags", {err_valid, len_valid, unhandled}, 0);
    endtask

    task automatic t_escape();
        w[0] = 32'h87;
        run(1, 16'd8);
        check("R2 escape", {st_ack, st_esc, st_unknown}, 3'b010);
    endtask

    task automatic t_unknown_status();
        w[0] = 32'h0000_0184; w[1] = 32'h0000_9921;
        run(2, 16'd0);
        check("R2 unknown", {st_ack, st_esc, st_unknown}, 3'b001);
        check("R5 short1 count", 32'(nb), 1);
        check("R5 short1 byte", 32'(got[0]), 32'h99);
    endtask

    task automatic t_err_report();
        w[0] = 32'h84; w[1] = 32'h00A5_C302; w[2] = 32'hDEAD_BEEF;
        run(3, 16'd16);
        check("R4 err_valid", 32'(err_valid), 1);
        check("R4 err_map", 32'(err_map), 32'hA5C3);
        check("R4 no bytes", 32'(nb), 0);
    endtask

    task automatic t_short2();
        w[0] = 32'h84; w[1] = 32'h003C_7E22;
        run(2, 16'd1);
        check("R5 short2 count", 32'(nb), 2);
        check("R5 short2 first", 32'(got[0]), 32'h7E);
        check("R5 short2 second", 32'(got[1]), 32'h3C);
    endtask

    task automatic t_long_cmd();
        w[0] = 32'h84; w[1] = 32'h0000_061C; w[2] = 32'h4433_2211; w[3] = 32'h8877_6655;
        run(4, 16'd10);
        check("R6 len_valid", 32'(len_valid), 1);
        check("R6 long_len", 32'(long_len), 6);
        check("R7 count", 32'(nb), 6);
        for (int i = 0; i < 6; i++) check("R7 byte order", 32'(got[i]), 32'(8'h11 * (i + 1)));
    endtask

    task automatic t_long_gen_clip();
        w[0] = 32'h84; w[1] = 32'h0001_021A; w[2] = 32'hA3A2_A1A0; w[3] = 32'hA7A6_A5A4;
        run(4, 16'd5);
        check("R6 long_len wide", 32'(long_len), 32'h0102);
        check("R7 clip by limit", 32'(nb), 5);
        check("R7 last byte", 32'(got[4]), 32'hA4);
    endtask

    task automatic t_long_short_supply();
        w[0] = 32'h84; w[1] = 32'h0001_001C; w[2] = 32'h0D0C_0B0A;
        run(3, 16'h0100);
        check("R7 clip by words", 32'(nb), 4);
        check("R7 word top byte", 32'(got[3]), 32'h0D);
    endtask

    task automatic t_long_zero_limit();
        w[0] = 32'h84; w[1] = 32'h0000_081A; w[2] = 32'h1; w[3] = 32'h2;
        run(4, 16'd0);
        check("R7 zero limit", 32'(nb), 0);
        check("R6 len kept", 32'(long_len), 8);
    endtask

    task automatic t_unhandled();
        w[0] = 32'h84; w[1] = 32'h0012_3405; w[2] = 32'h5555_5555;
        run(3, 16'd16);
        check("R8 unhandled", 32'(unhandled), 1);
        check("R8 no bytes", 32'(nb), 0);
        check("R8 others low", {err_valid, len_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ack_only();
        t_escape();
        t_unknown_status();
        t_err_report();
        t_short2();
        t_long_cmd();
        t_long_gen_clip();
        t_long_short_supply();
        t_long_zero_limit();
        t_unhandled();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule